// File: doc/BRIEF.md
# Double-Precision Floating-Point Multiplier

This block multiplies two 64-bit binary floating-point numbers (1 sign bit, 11-bit biased exponent with bias 1023, 52 stored fraction bits) and returns a packed 64-bit product. Each operand is split into sign, exponent and a 53-bit significand with the implicit leading one restored. The 106-bit significand product is not formed by one wide multiplier. A grid of narrow tile multipliers, each at most 24 by 17 bits, produces partial products. These are shifted to their bit offsets and summed. The product is then normalized, rounded to nearest with ties to even, and repacked.

A caller presents both operands together with a one-cycle `start` strobe. Exactly three clock cycles later the unit raises `outValid` for one cycle. In that cycle `result`, `overflow` and `underflow` are valid, and they hold until the next result. A new operation may start on every cycle.

Zero operands, infinities and NaNs follow a short fixed rule set. Subnormal operands are treated as zero. Results too large for the format become infinity. Results too small for a normal number become zero. Each of these two cases raises its own flag.

Top module: `fp64_mul`

## Requirements
- R1: An operation whose `start` is sampled high at clock edge N raises `outValid` after edge N+3 for exactly one cycle. Starts on consecutive cycles produce results on consecutive cycles, in order.
- R2: For two normal operands whose product is in range, `result` is the product rounded to nearest. The result sign is the XOR of the operand signs, and the exponent accounts for a product in [2,4).
- R3: When the discarded bits are exactly half an ulp, rounding goes to the value whose lowest fraction bit (bit 0) is 0. Bits above half always round up, and bits below half always round down.
- R4: When rounding carries out of the significand, the fraction becomes zero and the exponent increases by one.
- R5: A rounded result exponent of 2047 or more gives a signed infinity (exponent field all ones, fraction zero) with `overflow`=1 and `underflow`=0.
- R6: A rounded result exponent of 0 or less gives a signed zero with `underflow`=1 and `overflow`=0.
- R7: An operand with exponent field 0 (zero or subnormal), multiplied by a finite operand, gives a zero whose sign is the XOR of the operand signs. Both flags are 0.
- R8: Any NaN operand (exponent 2047, fraction nonzero) gives the quiet NaN 0x7FF8000000000000. Infinity times zero gives the same value. Both flags are 0.
- R9: Infinity times a nonzero finite number or infinity gives infinity, with the sign the XOR of the operand signs. Both flags are 0.
- R10: After reset, `outValid`, `result`, `overflow` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe: operands are valid |
| opA | input | 64 | First operand, packed binary64 |
| opB | input | 64 | Second operand, packed binary64 |
| outValid | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 64 | Packed binary64 product |
| overflow | output | 1 | Product exceeded the largest finite value |
| underflow | output | 1 | Product fell below the smallest normal value |

## Verification
The bench builds the unit with its default tile sizes of 24 and 17 bits. With a 53-bit significand this gives a 3 by 4 tile grid whose edge pieces are only 5 and 2 bits wide. Operands with ones in their lowest and highest significand bits therefore send carries through every tile and every offset in the sum. The chosen vectors include exact ties in both rounding directions and a round-up that carries into the exponent. They also cover both exponent limits, on the boundary and one step past it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam int BIAS   = 1023;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [63:0] QUIET_NAN = 64'h7FF8_0000_0000_0000;

  typedef enum logic [1:0] {CLS_NORM, CLS_ZERO, CLS_INF, CLS_NAN} fpmClass_t;

  typedef struct packed {
    logic load;
    logic sum;
    logic pack;
  } fpmStrobes_t;
endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output fpmStrobes_t strobes,
  output logic        outValid
);
  logic [1:0] stageValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= '0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= {stageValid[0], start};
      outValid   <= stageValid[1];
    end
  end

  always_comb begin
    strobes.load = start;
    strobes.sum  = stageValid[0];
    strobes.pack = stageValid[1];
  end
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int TILE_A = 24,
  parameter int TILE_B = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  fpmStrobes_t strobes,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic [63:0] result,
  output logic        overflow,
  output logic        underflow
);
  localparam int NA    = (SIG_W + TILE_A - 1) / TILE_A;
  localparam int NB    = (SIG_W + TILE_B - 1) / TILE_B;
  localparam int PP_W  = TILE_A + TILE_B;
  localparam int PAD_A = NA * TILE_A;
  localparam int PAD_B = NB * TILE_B;
  localparam int ACC_W = PAD_A + PAD_B;

  function automatic fpmClass_t classify(input logic [63:0] v);
    if (v[62:52] == EXP_MAX) return (v[51:0] != '0) ? CLS_NAN : CLS_INF;
    if (v[62:52] == '0)      return CLS_ZERO;
    return CLS_NORM;
  endfunction

  // ---- stage 1: unpack, special cases, tile products
  fpmClass_t clsA, clsB;
  logic [PAD_A-1:0] sigA;
  logic [PAD_B-1:0] sigB;
  logic resSign, isSpecial;
  logic [63:0] specVal;

  always_comb begin
    clsA = classify(opA);
    clsB = classify(opB);
    sigA = PAD_A'({1'b1, opA[51:0]});
    sigB = PAD_B'({1'b1, opB[51:0]});
    resSign = opA[63] ^ opB[63];
    isSpecial = (clsA != CLS_NORM) || (clsB != CLS_NORM);
    if (clsA == CLS_NAN || clsB == CLS_NAN ||
        (clsA == CLS_INF && clsB == CLS_ZERO) ||
        (clsA == CLS_ZERO && clsB == CLS_INF))
      specVal = QUIET_NAN;
    else if (clsA == CLS_INF || clsB == CLS_INF)
      specVal = {resSign, EXP_MAX, {FRAC_W{1'b0}}};
    else
      specVal = {resSign, 63'd0};
  end

  logic [PP_W-1:0] tileProd [NA][NB];
  logic                    s1Sign, s1Special;
  logic [63:0]             s1SpecVal;
  logic signed [EXT_W-1:0] s1Exp;

  for (genvar i = 0; i < NA; i++) begin : gRow
    for (genvar j = 0; j < NB; j++) begin : gCol
      always_ff @(posedge clk) begin
        if (strobes.load)
          tileProd[i][j] <= PP_W'(sigA[i*TILE_A +: TILE_A]) * PP_W'(sigB[j*TILE_B +: TILE_B]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      s1Sign    <= resSign;
      s1Special <= isSpecial;
      s1SpecVal <= specVal;
      s1Exp     <= $signed({2'b00, opA[62:52]}) + $signed({2'b00, opB[62:52]})
                   - EXT_W'(BIAS);
    end
  end

  // ---- stage 2: shifted sum of the tile grid
  logic [ACC_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NA; i++)
      for (int j = 0; j < NB; j++)
        acc = acc + (ACC_W'(tileProd[i][j]) << (i * TILE_A + j * TILE_B));
  end

  logic [PROD_W-1:0]       s2Prod;
  logic                    s2Sign, s2Special;
  logic [63:0]             s2SpecVal;
  logic signed [EXT_W-1:0] s2Exp;

  always_ff @(posedge clk) begin
    if (strobes.sum) begin
      s2Prod    <= acc[PROD_W-1:0];
      s2Sign    <= s1Sign;
      s2Special <= s1Special;
      s2SpecVal <= s1SpecVal;
      s2Exp     <= s1Exp;
    end
  end

  // ---- stage 3: normalize, round to nearest even, pack
  logic [PROD_W-1:0]       normProd;
  logic [FRAC_W-1:0]       keptFrac;
  logic                    guardBit, roundBit, stickyBit, roundUp, topBit, carryOut;
  logic [FRAC_W:0]         roundedFrac;
  logic signed [EXT_W-1:0] finalExp;

  always_comb begin
    topBit      = s2Prod[PROD_W-1];
    normProd    = topBit ? s2Prod : (s2Prod << 1);
    keptFrac    = normProd[PROD_W-2 -: FRAC_W];
    guardBit    = normProd[PROD_W-2-FRAC_W];
    roundBit    = normProd[PROD_W-3-FRAC_W];
    stickyBit   = |normProd[PROD_W-4-FRAC_W:0];
    roundUp     = guardBit & (roundBit | stickyBit | keptFrac[0]);
    roundedFrac = {1'b0, keptFrac} + (FRAC_W+1)'(roundUp);
    carryOut    = roundedFrac[FRAC_W];
    finalExp    = s2Exp + EXT_W'(topBit) + EXT_W'(carryOut);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (strobes.pack) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      if (s2Special) begin
        result <= s2SpecVal;
      end else if (finalExp >= $signed(EXT_W'(EXP_MAX))) begin
        result   <= {s2Sign, EXP_MAX, {FRAC_W{1'b0}}};
        overflow <= 1'b1;
      end else if (finalExp <= 0) begin
        result    <= {s2Sign, 63'd0};
        underflow <= 1'b1;
      end else begin
        result <= {s2Sign, finalExp[EXP_W-1:0], roundedFrac[FRAC_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/fp64_mul.sv
module fp64_mul
  import fpm_pkg::*;
#(
  parameter int TILE_A = 24,
  parameter int TILE_B = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic        outValid,
  output logic [63:0] result,
  output logic        overflow,
  output logic        underflow
);
  fpmStrobes_t strobes;

  fpm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .outValid(outValid)
  );

  fpm_datapath #(.TILE_A(TILE_A), .TILE_B(TILE_B)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB),
    .result(result), .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: rtl/fp64_mul_chk.sv
module fp64_mul_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        outValid,
  input logic [63:0] result,
  input logic        overflow,
  input logic        underflow
);
  AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    start |-> ##3 outValid);  // R1
  AST_VALID_HAS_START: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(start, 3));  // R1
  AST_RESULT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(result[62:52] == 11'h7FF && result[51:0] != '0))
      |-> result[63] == ($past(opA[63], 3) ^ $past(opB[63], 3)));  // R2
  AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && overflow) |-> (result[62:0] == 63'h7FF0_0000_0000_0000 && !underflow));  // R5
  AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && underflow) |-> (result[62:0] == '0 && !overflow));  // R6
  AST_NAN_IN_QNAN_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (start && opA[62:52] == 11'h7FF && opA[51:0] != '0)
      |-> ##3 (result == 64'h7FF8_0000_0000_0000 && !overflow && !underflow));  // R8
endmodule

bind fp64_mul fp64_mul_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
  .outValid(outValid), .result(result), .overflow(overflow), .underflow(underflow)
);

// File: tb/tb_fp64_mul.sv
module tb_fp64_mul;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        outValid, overflow, underflow;
  logic [63:0] result;

  int nChecks = 0;
  int nFails  = 0;

  fp64_mul dut (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .overflow(overflow), .underflow(underflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation and check pulse timing, result and flags.
  task automatic mulCase(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] expRes, input logic expOvf, input logic expUnf);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R1 valid low +1 ", req}, 64'(outValid), 64'd0);
    @(negedge clk);
    check({"R1 valid low +2 ", req}, 64'(outValid), 64'd0);
    @(negedge clk);
    check({"R1 valid high +3 ", req}, 64'(outValid), 64'd1);
    check({req, " result"}, result, expRes);
    check({req, " overflow"}, 64'(overflow), 64'(expOvf));
    check({req, " underflow"}, 64'(underflow), 64'(expUnf));
    @(negedge clk);
    check({"R1 single pulse ", req}, 64'(outValid), 64'd0);
  endtask

  task automatic resetCase();
    #1;
    check("R10 valid after reset", 64'(outValid), 64'd0);
    check("R10 result after reset", result, 64'd0);
    check("R10 flags after reset", {62'd0, overflow, underflow}, 64'd0);
  endtask

  task automatic backToBackCase();
    @(negedge clk);
    opA = 64'h3FF8_0000_0000_0000; opB = 64'h3FF8_0000_0000_0000; start = 1'b1;
    @(negedge clk);
    opA = 64'h4008_0000_0000_0000; opB = 64'h4008_0000_0000_0000;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R1 back-to-back first valid", 64'(outValid), 64'd1);
    check("R1 back-to-back first 1.5*1.5", result, 64'h4002_0000_0000_0000);
    @(negedge clk);
    check("R1 back-to-back second valid", 64'(outValid), 64'd1);
    check("R1 back-to-back second 3*3", result, 64'h4022_0000_0000_0000);
    @(negedge clk);
    check("R1 back-to-back ends", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    resetCase();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R2: normal products, with and without top product bit, sign XOR
    mulCase("R2 1*2",        64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 0);
    mulCase("R2 1.5*1.5",    64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0000, 64'h4002_0000_0000_0000, 0, 0);
    mulCase("R2 -2*3",       64'hC000_0000_0000_0000, 64'h4008_0000_0000_0000, 64'hC018_0000_0000_0000, 0, 0);
    mulCase("R2 -3*-3",      64'hC008_0000_0000_0000, 64'hC008_0000_0000_0000, 64'h4022_0000_0000_0000, 0, 0);
    // R3: below half rounds down, ties go to even in both directions
    mulCase("R3 below half", 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0002, 0, 0);
    mulCase("R3 tie odd up", 64'h3FF0_0000_0000_0001, 64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0002, 0, 0);
    mulCase("R3 tie even",   64'h3FF0_0000_0000_0003, 64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0004, 0, 0);
    // R4: rounding carries into exponent
    mulCase("R4 carry",      64'h3FFF_FFFF_FFFF_FFFE, 64'h3FF0_0000_0000_0001, 64'h4000_0000_0000_0000, 0, 0);
    // R5: overflow and its boundary
    mulCase("R5 top limit",  64'h7FE0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h7FE0_0000_0000_0000, 0, 0);
    mulCase("R5 overflow",   64'h7FE0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, 0);
    mulCase("R5 neg ovf",    64'hFFE0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1, 0);
    // R6: underflow and its boundary
    mulCase("R6 low limit",  64'h0010_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h0010_0000_0000_0000, 0, 0);
    mulCase("R6 underflow",  64'h8010_0000_0000_0000, 64'h3FE0_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1);
    // R7: zero and subnormal operands
    mulCase("R7 0*3",        64'h0000_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h0000_0000_0000_0000, 0, 0);
    mulCase("R7 -0*3",       64'h8000_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0);
    mulCase("R7 subnormal",  64'h0000_0000_0000_0001, 64'hBFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0);
    // R8: NaN in and infinity times zero
    mulCase("R8 nan*1",      64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000, 0, 0);
    mulCase("R8 0*nan",      64'h0000_0000_0000_0000, 64'hFFF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 0, 0);
    mulCase("R8 inf*0",      64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h7FF8_0000_0000_0000, 0, 0);
    // R9: infinity times finite or infinity
    mulCase("R9 inf*-2",     64'h7FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 0, 0);
    mulCase("R9 -inf*-inf",  64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 0, 0);
    backToBackCase();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule